// File: doc/BRIEF.md
# Banked Level Interrupt Register File

This block collects 72 level-sensitive interrupt request lines into three groups: eight local lines, then two banks of 32 shared lines each. Every line has an enable bit. A line that is high and enabled shows as pending. Lines are looked at as they are and are never captured, so a request goes away once the peripheral drops its line. A single registered level output asks the processor for service whenever any bit of the summary word is set.

Software reaches the block through a 32-bit register port with byte offsets. Each group has a set-style enable offset and a clear-style disable offset, so one store changes only the bits it names. The summary word holds the local pending lines, one flag per shared bank, and shortcut copies of eleven chosen shared lines. A handler can therefore often find its source without a second read. A bank flag counts only the enabled pending lines that have no shortcut copy. A fast-interrupt control word is kept as a plain storage register and routes nothing. Turning a pending word into a vector number is left to software.

Top module: `irqb_ctrl`

## Requirements
- R1: A write to offset 0x10, 0x14 or 0x18 sets the enable bits of bank 1, bank 2 or the local group (local uses data bits 7:0) wherever the data has a one. Bits written as zero keep their old value, and the enables change only on such writes or on disable writes.
- R2: A write to offset 0x1C, 0x20 or 0x24 clears the enable bits of bank 1, bank 2 or the local group wherever the data has a one. Bits written as zero keep their old value.
- R3: Offset 0x04 reads bank-1 lines AND bank-1 enables, and offset 0x08 reads the same for bank 2. Summary (offset 0x00) bits 7:0 hold the local lines AND the local enables.
- R4: Summary bit 8 is set when an enabled, high bank-1 line exists that is not one of 7, 9, 10, 18 or 19. Summary bit 9 is set when such a bank-2 line exists that is not one of 21, 22, 23, 24, 25 or 30.
- R5: Summary bits 10..14 carry the pending state of bank-1 lines 7, 9, 10, 18 and 19 in that order. Bits 15..20 carry the pending state of bank-2 lines 21, 22, 23, 24, 25 and 30 in that order.
- R6: Summary bits 31:21 always read as zero.
- R7: The irq output is high in the cycle after the summary word is nonzero, and low in the cycle after it is zero.
- R8: After reset all enables are zero, the fast-interrupt control word is zero, and irq is low.
- R9: The enable offset and the disable offset of a group both read that group's current enable mask. Local reads have bits 31:8 as zero.
- R10: Writes to offsets 0x00, 0x04 and 0x08 change no enable bit and no pending or summary value.
- R11: Offset 0x0C is a 32-bit read/write register whose value has no effect on irq or on any pending value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_local | input | 8 | Local request lines |
| src_bank1 | input | 32 | Bank-1 request lines |
| src_bank2 | input | 32 | Bank-2 request lines |
| reg_addr | input | 6 | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe, one cycle per store |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq | output | 1 | Registered level interrupt request |

## Verification
On every cycle the assertions check several things. A set or clear store changes the bank-1 mask exactly as OR or AND-NOT of the data. A cycle without an enable store leaves all three masks unchanged. irq follows the summary word one cycle late. Summary reads never show bits 31:21. A raised bank flag always has some enabled, high, non-shortcut line behind it. The shortcut bit order, the use of the disable offsets as read-back ports, and the fact that stores to the pending offsets and the fast-interrupt word do nothing can be shown only by the bench. Its directed scenarios compare whole register reads against a model that builds the summary from its own index lists.

// File: rtl/irqb_pkg.sv
package irqb_pkg;
  localparam int LOCAL_N  = 8;
  localparam int BANK_W   = 32;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 6;
  localparam int SC1_N    = 5;
  localparam int SC2_N    = 6;

  // summary word field positions (software decodes these)
  localparam int SUM_F1   = LOCAL_N;
  localparam int SUM_F2   = LOCAL_N + 1;
  localparam int SUM_SC1  = LOCAL_N + 2;
  localparam int SUM_SC2  = SUM_SC1 + SC1_N;
  localparam int SUM_USED = SUM_SC2 + SC2_N;

  localparam int SC1_IDX [SC1_N] = '{7, 9, 10, 18, 19};
  localparam int SC2_IDX [SC2_N] = '{21, 22, 23, 24, 25, 30};

  localparam logic [ADDR_W-1:0] OFS_SUMMARY = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_PEND1   = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_PEND2   = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_FASTCTL = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_SET1    = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_SET2    = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_SETL    = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_CLR1    = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_CLR2    = 6'h20;
  localparam logic [ADDR_W-1:0] OFS_CLRL    = 6'h24;

  function automatic logic [BANK_W-1:0] sc1_mask();
    logic [BANK_W-1:0] m;
    m = '0;
    for (int i = 0; i < SC1_N; i++) m[SC1_IDX[i]] = 1'b1;
    return m;
  endfunction

  function automatic logic [BANK_W-1:0] sc2_mask();
    logic [BANK_W-1:0] m;
    m = '0;
    for (int i = 0; i < SC2_N; i++) m[SC2_IDX[i]] = 1'b1;
    return m;
  endfunction

  function automatic logic [SC1_N-1:0] sc1_pick(input logic [BANK_W-1:0] p);
    logic [SC1_N-1:0] r;
    for (int i = 0; i < SC1_N; i++) r[i] = p[SC1_IDX[i]];
    return r;
  endfunction

  function automatic logic [SC2_N-1:0] sc2_pick(input logic [BANK_W-1:0] p);
    logic [SC2_N-1:0] r;
    for (int i = 0; i < SC2_N; i++) r[i] = p[SC2_IDX[i]];
    return r;
  endfunction
endpackage

// File: rtl/irqb_enable_reg.sv
module irqb_enable_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] mask,
  output logic [W-1:0] en
);
  logic [W-1:0] set_bits;
  logic [W-1:0] clr_bits;

  assign set_bits = set_we ? mask : '0;
  assign clr_bits = clr_we ? mask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en <= '0;
    else        en <= (en | set_bits) & ~clr_bits;
  end
endmodule

// File: rtl/irqb_summary.sv
module irqb_summary
  import irqb_pkg::*;
(
  input  logic [LOCAL_N-1:0] pend_l,
  input  logic [BANK_W-1:0]  pend1,
  input  logic [BANK_W-1:0]  pend2,
  output logic               flag1,
  output logic               flag2,
  output logic [DATA_W-1:0]  summary
);
  localparam logic [BANK_W-1:0] SC1_M = sc1_mask();
  localparam logic [BANK_W-1:0] SC2_M = sc2_mask();

  assign flag1 = |(pend1 & ~SC1_M);
  assign flag2 = |(pend2 & ~SC2_M);

  always_comb begin
    summary = '0;
    summary[LOCAL_N-1:0]           = pend_l;
    summary[SUM_F1]                = flag1;
    summary[SUM_F2]                = flag2;
    summary[SUM_SC2-1:SUM_SC1]     = sc1_pick(pend1);
    summary[SUM_USED-1:SUM_SC2]    = sc2_pick(pend2);
  end
endmodule

// File: rtl/irqb_readmux.sv
module irqb_readmux
  import irqb_pkg::*;
(
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  summary,
  input  logic [BANK_W-1:0]  pend1,
  input  logic [BANK_W-1:0]  pend2,
  input  logic [DATA_W-1:0]  fastctl,
  input  logic [LOCAL_N-1:0] en_l,
  input  logic [BANK_W-1:0]  en1,
  input  logic [BANK_W-1:0]  en2,
  output logic [DATA_W-1:0]  rdata
);
  always_comb begin
    rdata = '0;
    unique case (addr)
      OFS_SUMMARY:          rdata = summary;
      OFS_PEND1:            rdata[BANK_W-1:0] = pend1;
      OFS_PEND2:            rdata[BANK_W-1:0] = pend2;
      OFS_FASTCTL:          rdata = fastctl;
      OFS_SET1, OFS_CLR1:   rdata[BANK_W-1:0] = en1;
      OFS_SET2, OFS_CLR2:   rdata[BANK_W-1:0] = en2;
      OFS_SETL, OFS_CLRL:   rdata[LOCAL_N-1:0] = en_l;
      default:              rdata = '0;
    endcase
  end
endmodule

// File: rtl/irqb_ctrl.sv
module irqb_ctrl
  import irqb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LOCAL_N-1:0] src_local,
  input  logic [BANK_W-1:0]  src_bank1,
  input  logic [BANK_W-1:0]  src_bank2,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               irq
);
  // named write strobes, visible to the checker
  logic set1_we, set2_we, setl_we;
  logic clr1_we, clr2_we, clrl_we;
  logic fast_we;
  logic en_touch;

  assign set1_we = reg_wr && (reg_addr == OFS_SET1);
  assign set2_we = reg_wr && (reg_addr == OFS_SET2);
  assign setl_we = reg_wr && (reg_addr == OFS_SETL);
  assign clr1_we = reg_wr && (reg_addr == OFS_CLR1);
  assign clr2_we = reg_wr && (reg_addr == OFS_CLR2);
  assign clrl_we = reg_wr && (reg_addr == OFS_CLRL);
  assign fast_we = reg_wr && (reg_addr == OFS_FASTCTL);
  assign en_touch = set1_we | set2_we | setl_we | clr1_we | clr2_we | clrl_we;

  logic [LOCAL_N-1:0] en_l;
  logic [BANK_W-1:0]  en1;
  logic [BANK_W-1:0]  en2;

  irqb_enable_reg #(.W(LOCAL_N)) u_en_local (
    .clk(clk), .rst_n(rst_n), .set_we(setl_we), .clr_we(clrl_we),
    .mask(reg_wdata[LOCAL_N-1:0]), .en(en_l));

  irqb_enable_reg #(.W(BANK_W)) u_en_bank1 (
    .clk(clk), .rst_n(rst_n), .set_we(set1_we), .clr_we(clr1_we),
    .mask(reg_wdata[BANK_W-1:0]), .en(en1));

  irqb_enable_reg #(.W(BANK_W)) u_en_bank2 (
    .clk(clk), .rst_n(rst_n), .set_we(set2_we), .clr_we(clr2_we),
    .mask(reg_wdata[BANK_W-1:0]), .en(en2));

  // fast-interrupt control: storage only
  logic [DATA_W-1:0] fastctl;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fastctl <= '0;
    else if (fast_we) fastctl <= reg_wdata;
  end

  logic [LOCAL_N-1:0] pend_l;
  logic [BANK_W-1:0]  pend1;
  logic [BANK_W-1:0]  pend2;
  assign pend_l = src_local & en_l;
  assign pend1  = src_bank1 & en1;
  assign pend2  = src_bank2 & en2;

  logic              flag1, flag2;
  logic [DATA_W-1:0] summary;

  irqb_summary u_summary (
    .pend_l(pend_l), .pend1(pend1), .pend2(pend2),
    .flag1(flag1), .flag2(flag2), .summary(summary));

  irqb_readmux u_readmux (
    .addr(reg_addr), .summary(summary), .pend1(pend1), .pend2(pend2),
    .fastctl(fastctl), .en_l(en_l), .en1(en1), .en2(en2),
    .rdata(reg_rdata));

  logic any_pending;
  assign any_pending = |summary;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= any_pending;
  end
endmodule

// File: rtl/irqb_checker.sv
module irqb_checker
  import irqb_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               set1_we,
  input logic               clr1_we,
  input logic               en_touch,
  input logic [DATA_W-1:0]  reg_wdata,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [DATA_W-1:0]  reg_rdata,
  input logic [LOCAL_N-1:0] en_l,
  input logic [BANK_W-1:0]  en1,
  input logic [BANK_W-1:0]  en2,
  input logic [BANK_W-1:0]  src_bank1,
  input logic [DATA_W-1:0]  summary,
  input logic               irq
);
  localparam logic [BANK_W-1:0] NON_SC1 = ~sc1_mask();

  AST_SET_ORS_IN: assert property (@(posedge clk) disable iff (!rst_n)
    set1_we |=> en1 == ($past(en1) | $past(reg_wdata[BANK_W-1:0]))); // R1
  AST_CLR_MASKS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    clr1_we |=> en1 == ($past(en1) & ~$past(reg_wdata[BANK_W-1:0]))); // R2
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en_touch |=> ($stable(en1) && $stable(en2) && $stable(en_l))); // R10
  AST_FLAG1_BACKED: assert property (@(posedge clk) disable iff (!rst_n)
    summary[SUM_F1] |-> |(src_bank1 & en1 & NON_SC1)); // R4
  AST_SUM_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == OFS_SUMMARY) |-> reg_rdata[DATA_W-1:SUM_USED] == '0); // R6
  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (summary != '0) |=> irq); // R7
  AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (summary == '0) |=> !irq); // R7
endmodule

bind irqb_ctrl irqb_checker chk_i (
  .clk(clk), .rst_n(rst_n), .set1_we(set1_we), .clr1_we(clr1_we),
  .en_touch(en_touch), .reg_wdata(reg_wdata), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .en_l(en_l), .en1(en1), .en2(en2),
  .src_bank1(src_bank1), .summary(summary), .irq(irq));

// File: tb/irqb_ctrl_tb_top.sv
module irqb_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  src_local = '0;
  logic [31:0] src_bank1 = '0;
  logic [31:0] src_bank2 = '0;
  logic [5:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model state
  logic [7:0]  m_enl = '0;
  logic [31:0] m_en1 = '0;
  logic [31:0] m_en2 = '0;

  always #2 clk = ~clk;

  irqb_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .src_local(src_local), .src_bank1(src_bank1),
    .src_bank2(src_bank2), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // model of the summary word built from index lists
  function automatic logic [31:0] model_summary();
    int l1 [5] = '{7, 9, 10, 18, 19};
    int l2 [6] = '{21, 22, 23, 24, 25, 30};
    logic [31:0] p1, p2, r, rest1, rest2;
    p1 = src_bank1 & m_en1;
    p2 = src_bank2 & m_en2;
    rest1 = p1; rest2 = p2;
    r = {24'h0, src_local & m_enl};
    foreach (l1[k]) begin r[10 + k] = p1[l1[k]]; rest1[l1[k]] = 1'b0; end
    foreach (l2[k]) begin r[15 + k] = p2[l2[k]]; rest2[l2[k]] = 1'b0; end
    r[8] = (rest1 != 0);
    r[9] = (rest2 != 0);
    return r;
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    rd(6'h00, v); chk("R8 summary", v, 0);
    rd(6'h10, v); chk("R8 en1", v, 0);
    rd(6'h14, v); chk("R8 en2", v, 0);
    rd(6'h18, v); chk("R8 enl", v, 0);
    rd(6'h0C, v); chk("R8 fastctl", v, 0);
    chk("R8 irq", {31'h0, irq}, 0);
  endtask

  task automatic t_set_clear();
    logic [31:0] v;
    wr(6'h10, 32'h0000_0003); wr(6'h10, 32'h0000_0004); m_en1 = 32'h7;
    rd(6'h10, v); chk("R1 set accumulates", v, 32'h7);
    rd(6'h1C, v); chk("R9 disable offset reads mask", v, 32'h7);
    wr(6'h1C, 32'h0000_0001); m_en1 = 32'h6;
    rd(6'h10, v); chk("R2 clear one bit", v, 32'h6);
    wr(6'h14, 32'hF000_000F); wr(6'h20, 32'h3000_0003); m_en2 = 32'hC000_000C;
    rd(6'h20, v); chk("R2 bank2 partial clear", v, 32'hC000_000C);
    rd(6'h10, v); chk("R1 bank1 untouched by bank2 writes", v, 32'h6);
  endtask

  task automatic t_local();
    logic [31:0] v;
    wr(6'h18, 32'hFFFF_FF81); m_enl = 8'h81;
    rd(6'h24, v); chk("R9 local mask upper zero", v, 32'h81);
    src_local = 8'hFF;
    rd(6'h00, v); chk("R3 local pending in summary", v, model_summary());
    chk("R3 local low byte", {24'h0, v[7:0]}, 32'h81);
    wr(6'h24, 32'h0000_0080); m_enl = 8'h01;
    rd(6'h18, v); chk("R2 local clear", v, 32'h01);
    src_local = 8'h00;
  endtask

  task automatic t_pending();
    logic [31:0] v;
    src_bank1 = 32'hFFFF_FFFF;
    rd(6'h04, v); chk("R3 bank1 pending", v, 32'h6);
    rd(6'h00, v); chk("R4 bank1 flag", v, model_summary());
    chk("R4 bit8 set", {31'h0, v[8]}, 1);
    src_bank2 = 32'h4000_0004;
    rd(6'h08, v); chk("R3 bank2 pending", v, 32'h4000_0004);
    src_bank1 = '0; src_bank2 = '0;
  endtask

  task automatic t_shortcut();
    logic [31:0] v;
    wr(6'h1C, 32'hFFFF_FFFF); wr(6'h20, 32'hFFFF_FFFF); m_en1 = 0; m_en2 = 0;
    wr(6'h10, 32'h0000_0080); m_en1 = 32'h80;       // line 7
    wr(6'h14, 32'h4000_0000); m_en2 = 32'h4000_0000; // line 30
    src_bank1 = 32'hFFFF_FFFF; src_bank2 = 32'hFFFF_FFFF;
    rd(6'h00, v);
    chk("R5 shortcut only", v, model_summary());
    chk("R5 bit10 and bit20", v, 32'h0010_0400);
    chk("R4 flags clear for shortcut lines", {30'h0, v[9:8]}, 0);
    wr(6'h10, 32'h000C_0600); m_en1 = 32'h000C_0680;  // 9,10,18,19
    wr(6'h14, 32'h03E0_0000); m_en2 = 32'h43E0_0000;  // 21..25
    rd(6'h00, v); chk("R5 all shortcut bits", v, 32'h001F_FC00);
    wr(6'h10, 32'hFFFF_FFFF); wr(6'h14, 32'hFFFF_FFFF);
    wr(6'h18, 32'hFF); m_en1 = '1; m_en2 = '1; m_enl = 8'hFF;
    src_local = 8'hFF;
    rd(6'h00, v); chk("R6 upper bits zero with all set", v, 32'h001F_FFFF);
    src_local = 0; src_bank1 = 0; src_bank2 = 0;
  endtask

  task automatic t_ignored_writes();
    logic [31:0] v;
    src_bank1 = 32'h0000_0100;
    wr(6'h00, 32'h0000_0000); wr(6'h04, 32'h0000_0000); wr(6'h08, 32'h0000_0000);
    rd(6'h10, v); chk("R10 en1 kept", v, m_en1);
    rd(6'h14, v); chk("R10 en2 kept", v, m_en2);
    rd(6'h04, v); chk("R10 pend1 kept", v, 32'h0000_0100);
    rd(6'h00, v); chk("R10 summary kept", v, model_summary());
    src_bank1 = 0;
  endtask

  task automatic t_irq_and_fast();
    logic [31:0] v;
    wr(6'h1C, '1); wr(6'h20, '1); wr(6'h24, '1); m_en1 = 0; m_en2 = 0; m_enl = 0;
    wr(6'h0C, 32'hA5A5_0001);
    rd(6'h0C, v); chk("R11 fastctl readback", v, 32'hA5A5_0001);
    @(negedge clk); chk("R11 irq low with fastctl set", {31'h0, irq}, 0);
    wr(6'h14, 32'h0000_0001); m_en2 = 1;
    @(negedge clk); src_bank2 = 32'h1;
    chk("R7 irq still low same cycle", {31'h0, irq}, 0);
    @(negedge clk); chk("R7 irq high one cycle later", {31'h0, irq}, 1);
    src_bank2 = 0;
    @(negedge clk); chk("R7 irq low after source drops", {31'h0, irq}, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_set_clear();
    t_local();
    t_pending();
    t_shortcut();
    t_ignored_writes();
    t_irq_and_fast();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule